// File: doc/BRIEF.md
# FIFO Level Interrupt Aggregator

This block turns the fill state of up to eight inbound and eight outbound stream FIFOs into two level-sensitive interrupt requests, one per direction. Software programs a single 32-bit configuration register. For every link that register holds an enable bit and a condition-select bit. The select bit chooses which fill-level condition of that link may raise the request of its direction.

An inbound link can request service either when its FIFO holds any data or when it has reached half of its capacity. An outbound link can request either when its FIFO has any free slot or when it has fallen below half of its capacity. The conditions of all enabled links of one direction are ORed together, gated by a global enable, and registered once. A request therefore stays high for as long as any cause remains. It drops one cycle after the cause is resolved, for example after the FIFO has been drained or refilled.

When the FIFO depth of a direction is 1, a half-level condition has no meaning. All select bits of that direction are then tied to the "any data / any space" condition. Links beyond the implemented count read back as zero and never raise a request.

Top module: `lia_irq_agg`

## Requirements
- R1: A write with `reg_addr` equal to 8 loads the configuration register. In that register, bits 31:24 are the inbound enables, bits 23:16 the inbound selects, bits 15:8 the outbound enables and bits 7:0 the outbound selects, with bit n of each field belonging to link n. While `reg_addr` is 8, `reg_rdata` shows the register, and bits of links that are not implemented read as zero.
- R2: A write at any other address leaves the register unchanged. While `reg_addr` is not 8, `reg_rdata` reads as zero.
- R3: An enabled inbound link whose select bit is 1 requests when its `in_empty` bit is low.
- R4: An enabled inbound link whose select bit is 0 requests when its `in_half` bit (fill count at least depth/2) is high.
- R5: An enabled outbound link whose select bit is 1 requests when its `out_full` bit is low.
- R6: An enabled outbound link whose select bit is 0 requests when its `out_half` bit (fill count at least depth/2) is low, that is, when the FIFO is below half full.
- R7: When the depth of a direction is 1, every select bit of an implemented link of that direction reads as 1, and a write cannot clear it.
- R8: While `glb_en` is low, neither `irq_in` nor `irq_out` is raised.
- R9: A link whose enable bit is 0 does not contribute to a request. Flag inputs of unimplemented links have no effect.
- R10: `irq_in` is the OR of the conditions of all enabled inbound links, and `irq_out` is the OR of the conditions of all enabled outbound links.
- R11: Each request is registered. It reflects the inputs and the register as they were at the previous clock edge, and it stays high for as long as the condition holds.
- R12: The synchronous active-low reset clears all enable bits and all select bits that are not tied, and holds both requests low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en | input | 1 | Global enable for both requests |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Register read-back (zero at other offsets) |
| in_empty | input | NUM_IN | Inbound FIFO empty, one bit per link |
| in_half | input | NUM_IN | Inbound FIFO at least half full |
| out_full | input | NUM_OUT | Outbound FIFO full |
| out_half | input | NUM_OUT | Outbound FIFO at least half full |
| irq_in | output | 1 | Inbound interrupt request (level) |
| irq_out | output | 1 | Outbound interrupt request (level) |

## Verification
The bench runs two configurations side by side. One has half-level selection available and a partial outbound link count. The other has depth-1 FIFOs with tied select bits and a partial inbound link count. The corner cases it targets are these:
- Flags raised only on unimplemented links: a design that ignored the link count would fire.
- A select bit of 0 on an outbound link: a design that confused "below half" with "at least half" would invert the request.
- An attempt to clear tied select bits: a design that lost the tie would drop to the half-level condition and stay silent or fire wrongly.
- A write at a neighbouring offset: a design that decoded loosely would corrupt the enables.
- A cause that stays active, then clears: this exposes a design that pulses instead of holding the level, or that lags by the wrong number of cycles.

// File: rtl/lia_pkg.sv
// Package: shared layout of the interrupt configuration register.
// Assumes at most eight links per direction.
package lia_pkg;

    localparam int MAX_LINKS = 8;
    localparam int REG_W     = 32;

    // Field order matches the register bit layout, from MSB to LSB.
    typedef struct packed {
        logic [MAX_LINKS-1:0] in_en;
        logic [MAX_LINKS-1:0] in_sel;
        logic [MAX_LINKS-1:0] out_en;
        logic [MAX_LINKS-1:0] out_sel;
    } lia_cfg_t;

    // Returns a mask with the low n link bits set.
    function automatic logic [MAX_LINKS-1:0] link_mask(int n);
        logic [MAX_LINKS-1:0] m;
        m = '0;
        for (int i = 0; i < MAX_LINKS; i++) begin
            if (i < n) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/lia_dir_bits.sv
// Module: enable and select storage for one direction.
// Holds the per-link enable bits and, unless the direction's FIFO depth is 1,
// the per-link select bits. Unimplemented link bits are masked to zero.
// Assumes 1 <= NUM <= MAX_LINKS.
module lia_dir_bits
    import lia_pkg::*;
#(
    parameter int NUM       = 8,
    parameter bit FIXED_SEL = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit,
    input  logic [MAX_LINKS-1:0] en_wd,
    input  logic [MAX_LINKS-1:0] sel_wd,
    output logic [MAX_LINKS-1:0] en_v,
    output logic [MAX_LINKS-1:0] sel_v
);

    localparam logic [MAX_LINKS-1:0] MASK = link_mask(NUM);

    logic [MAX_LINKS-1:0] en_q;

    // Enable bits: cleared by reset, loaded on a register hit.
    always_ff @(posedge clk) begin
        if (!rst_n)   en_q <= '0;
        else if (hit) en_q <= en_wd & MASK;
    end

    assign en_v = en_q;

    generate
        if (FIXED_SEL) begin : g_fixed
            // Depth 1: the select bits are tied to the "any data / any space" condition.
            assign sel_v = MASK;
            logic unused_sel_wd;
            assign unused_sel_wd = ^sel_wd;
        end else begin : g_stored
            logic [MAX_LINKS-1:0] sel_q;
            // Select bits: cleared by reset, loaded on a register hit.
            always_ff @(posedge clk) begin
                if (!rst_n)   sel_q <= '0;
                else if (hit) sel_q <= sel_wd & MASK;
            end
            assign sel_v = sel_q;
        end
    endgenerate

    // R12: enables are zero in the cycle after reset.
    assert_reset_clears_R12: assert property (@(posedge clk)
        !rst_n |=> (en_v == '0))
        else $error("enable bits not cleared by reset");

endmodule

// File: rtl/lia_cfg_reg.sv
// Module: the memory-mapped interrupt configuration register.
// Decodes a write at OFFSET and drives the read-back, which is zero at other offsets.
// Assumes a single-cycle write strobe and combinational read.
module lia_cfg_reg
    import lia_pkg::*;
#(
    parameter int NUM_IN    = 8,
    parameter int NUM_OUT   = 8,
    parameter int IN_DEPTH  = 4,
    parameter int OUT_DEPTH = 4,
    parameter int ADDR_W    = 4,
    parameter int OFFSET    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output lia_cfg_t          cfg,
    output logic [REG_W-1:0]  rdata
);

    localparam logic [MAX_LINKS-1:0] IN_MASK  = link_mask(NUM_IN);
    localparam logic [MAX_LINKS-1:0] OUT_MASK = link_mask(NUM_OUT);

    lia_cfg_t wr_view;
    logic     sel_match;
    logic     hit;

    assign wr_view   = lia_cfg_t'(wdata);
    assign sel_match = (addr == ADDR_W'(OFFSET));
    assign hit       = we && sel_match;

    lia_dir_bits #(.NUM(NUM_IN), .FIXED_SEL(IN_DEPTH == 1)) u_in_bits (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .en_wd  (wr_view.in_en),
        .sel_wd (wr_view.in_sel),
        .en_v   (cfg.in_en),
        .sel_v  (cfg.in_sel)
    );

    lia_dir_bits #(.NUM(NUM_OUT), .FIXED_SEL(OUT_DEPTH == 1)) u_out_bits (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .en_wd  (wr_view.out_en),
        .sel_wd (wr_view.out_sel),
        .en_v   (cfg.out_en),
        .sel_v  (cfg.out_sel)
    );

    // Read-back: the register at OFFSET, zero elsewhere.
    always_comb begin
        rdata = sel_match ? REG_W'(cfg) : '0;
    end

    // R1: a write at the offset lands the masked enable fields.
    assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cfg.in_en == ($past(wdata[31:24]) & IN_MASK)) &&
                (cfg.out_en == ($past(wdata[15:8]) & OUT_MASK)))
        else $error("register write did not land");

    // R2: a write at another offset leaves the register untouched.
    assert_bad_offset_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !sel_match) |=> $stable(cfg))
        else $error("write at foreign offset changed register");

endmodule

// File: rtl/lia_dir_req.sv
// Module: per-direction condition selection and OR reduction.
// IS_OUT=0: select 1 -> not empty, select 0 -> at least half.
// IS_OUT=1: select 1 -> not full,  select 0 -> below half.
// lvl_a is the empty (inbound) or full (outbound) flag. Output is combinational.
module lia_dir_req
    import lia_pkg::*;
#(
    parameter int NUM    = 8,
    parameter bit IS_OUT = 1'b0
) (
    input  logic [MAX_LINKS-1:0] en_v,
    input  logic [MAX_LINKS-1:0] sel_v,
    input  logic [NUM-1:0]       lvl_a,
    input  logic [NUM-1:0]       lvl_half,
    output logic                 req
);

    localparam logic [MAX_LINKS-1:0] MASK = link_mask(NUM);

    logic [MAX_LINKS-1:0] raw_v;
    logic [MAX_LINKS-1:0] hit_v;
    logic                 unused_sel;

    generate
        for (genvar i = 0; i < MAX_LINKS; i++) begin : g_link
            if (i < NUM) begin : g_impl
                logic half_cond;
                if (IS_OUT) begin : g_out
                    assign half_cond = ~lvl_half[i];
                end else begin : g_in
                    assign half_cond = lvl_half[i];
                end
                assign raw_v[i] = sel_v[i] ? ~lvl_a[i] : half_cond;
            end else begin : g_none
                assign raw_v[i] = 1'b0;
            end
        end
    endgenerate

    assign unused_sel = ^(sel_v & ~MASK);

    // Gate each link by its enable, then reduce to one request.
    always_comb begin
        hit_v = en_v & raw_v;
        req   = |hit_v;
    end

endmodule

// File: rtl/lia_irq_agg.sv
// Module: top of the FIFO level interrupt aggregator.
// Combines the configuration register with both direction reducers, applies the
// global enable and registers both requests (one cycle of latency).
// Assumes NUM_IN and NUM_OUT in 1..8, and flags synchronous to clk.
module lia_irq_agg
    import lia_pkg::*;
#(
    parameter int NUM_IN    = 8,
    parameter int NUM_OUT   = 8,
    parameter int IN_DEPTH  = 4,
    parameter int OUT_DEPTH = 4,
    parameter int ADDR_W    = 4,
    parameter int OFFSET    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glb_en,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_IN-1:0]  in_empty,
    input  logic [NUM_IN-1:0]  in_half,
    input  logic [NUM_OUT-1:0] out_full,
    input  logic [NUM_OUT-1:0] out_half,
    output logic               irq_in,
    output logic               irq_out
);

    lia_cfg_t cfg;
    logic     in_req;
    logic     out_req;

    lia_cfg_reg #(
        .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .IN_DEPTH(IN_DEPTH),
        .OUT_DEPTH(OUT_DEPTH), .ADDR_W(ADDR_W), .OFFSET(OFFSET)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .cfg   (cfg),
        .rdata (reg_rdata)
    );

    lia_dir_req #(.NUM(NUM_IN), .IS_OUT(1'b0)) u_in_req (
        .en_v     (cfg.in_en),
        .sel_v    (cfg.in_sel),
        .lvl_a    (in_empty),
        .lvl_half (in_half),
        .req      (in_req)
    );

    lia_dir_req #(.NUM(NUM_OUT), .IS_OUT(1'b1)) u_out_req (
        .en_v     (cfg.out_en),
        .sel_v    (cfg.out_sel),
        .lvl_a    (out_full),
        .lvl_half (out_half),
        .req      (out_req)
    );

    // Output registers: gated by the global enable, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_in  <= 1'b0;
            irq_out <= 1'b0;
        end else begin
            irq_in  <= glb_en & in_req;
            irq_out <= glb_en & out_req;
        end
    end

    // R8: a cleared global enable keeps both lines low in the next cycle.
    assert_gate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> (!irq_in && !irq_out))
        else $error("request raised while globally disabled");

    // R11: a rising request needs the global enable one cycle earlier.
    assert_rise_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_in) |-> $past(glb_en))
        else $error("request rose without enable");

    // R9: no inbound enables means no inbound request in the next cycle.
    assert_no_enable_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.in_en == '0) |=> !irq_in)
        else $error("inbound request with all links disabled");

endmodule

// File: tb/sim_lia_irq_agg.sv
`timescale 1ns/1ps
module sim_lia_irq_agg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glb_en = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wd = 32'd0;
    logic [7:0]  emp = 8'hFF, ihf = 8'h00, full = 8'h00, ohf = 8'h00;
    logic [31:0] rd0, rd1;
    logic        i0, o0, i1, o1;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    bit    mv = 1'b0;
    string cur_req = "R12";

    logic [31:0] m0, m1;
    logic        e0i, e0o, e1i, e1o;

    always #2.5 clk = ~clk;

    // u0: half-level selection available, five outbound links.
    lia_irq_agg #(.NUM_IN(8), .NUM_OUT(5), .IN_DEPTH(4), .OUT_DEPTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wd), .reg_rdata(rd0), .in_empty(emp), .in_half(ihf),
        .out_full(full[4:0]), .out_half(ohf[4:0]), .irq_in(i0), .irq_out(o0));

    // u1: depth-1 FIFOs with tied selects, three inbound links.
    lia_irq_agg #(.NUM_IN(3), .NUM_OUT(8), .IN_DEPTH(1), .OUT_DEPTH(1)) u1 (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wd), .reg_rdata(rd1), .in_empty(emp[2:0]), .in_half(ihf[2:0]),
        .out_full(full), .out_half(ohf), .irq_in(i1), .irq_out(o1));

    function automatic logic [7:0] msk(int n);
        logic [7:0] m = '0;
        for (int i = 0; i < n; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] rst_cfg(int ni, int no, int di, int dout);
        logic [31:0] r = '0;
        if (di == 1)   r[23:16] = msk(ni);
        if (dout == 1) r[7:0]   = msk(no);
        return r;
    endfunction

    function automatic logic [31:0] wr_cfg(logic [31:0] cur, int ni, int no, int di, int dout);
        logic [31:0] r = cur;
        if (we && addr == 4'd8) begin
            r[31:24] = wd[31:24] & msk(ni);
            r[23:16] = (di == 1)   ? msk(ni) : (wd[23:16] & msk(ni));
            r[15:8]  = wd[15:8] & msk(no);
            r[7:0]   = (dout == 1) ? msk(no) : (wd[7:0] & msk(no));
        end
        return r;
    endfunction

    function automatic logic req_in(logic [31:0] c, int ni);
        for (int i = 0; i < ni; i++)
            if (c[24+i] && (c[16+i] ? !emp[i] : ihf[i])) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic req_out(logic [31:0] c, int no);
        for (int i = 0; i < no; i++)
            if (c[8+i] && (c[i] ? !full[i] : !ohf[i])) return 1'b1;
        return 1'b0;
    endfunction

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m0 <= rst_cfg(8, 5, 4, 4);
            m1 <= rst_cfg(3, 8, 1, 1);
            e0i <= 1'b0; e0o <= 1'b0; e1i <= 1'b0; e1o <= 1'b0;
        end else begin
            e0i <= glb_en && req_in(m0, 8);
            e0o <= glb_en && req_out(m0, 5);
            e1i <= glb_en && req_in(m1, 3);
            e1o <= glb_en && req_out(m1, 8);
            m0 <= wr_cfg(m0, 8, 5, 4, 4);
            m1 <= wr_cfg(m1, 3, 8, 1, 1);
        end
        mv <= 1'b1;
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
        end
    endtask

    // Compare on every falling edge, away from the active edge.
    always @(negedge clk) begin
        if (mv && !done) begin
            chk("u0.irq_in",  32'(i0), 32'(e0i));
            chk("u0.irq_out", 32'(o0), 32'(e0o));
            chk("u1.irq_in",  32'(i1), 32'(e1i));
            chk("u1.irq_out", 32'(o1), 32'(e1o));
            chk("u0.rdata", rd0, (addr == 4'd8) ? m0 : 32'd0);
            chk("u1.rdata", rd1, (addr == 4'd8) ? m1 : 32'd0);
        end
    end

    task automatic drv(input logic w, input logic [3:0] a, input logic [31:0] d,
                       input logic g, input logic [7:0] e, h, f, oh);
        @(posedge clk); #1;
        we = w; addr = a; wd = d; glb_en = g; emp = e; ihf = h; full = f; ohf = oh;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drv(1'b0, 4'd8, 32'd0, glb_en, emp, ihf, full, ohf);
    endtask

    initial begin
        // R12: reset state and read-back.
        cur_req = "R12";
        drv(0, 8, 0, 1, 8'hFF, 8'h00, 8'hFF, 8'hFF);
        idle(3);
        @(posedge clk); #1 rst_n = 1'b1;
        idle(2);
        // R1: full write, unimplemented bits must read zero.
        cur_req = "R1";
        drv(1, 8, 32'hFFFF_FFFF, 1, 8'hFF, 8'h00, 8'hFF, 8'hFF);
        idle(2);
        // R2: foreign offset write ignored, foreign read zero.
        cur_req = "R2";
        drv(1, 4, 32'h0000_0000, 1, 8'hFF, 8'h00, 8'hFF, 8'hFF);
        drv(0, 4, 0, 1, 8'hFF, 8'h00, 8'hFF, 8'hFF);
        idle(2);
        // R3: inbound not-empty condition.
        cur_req = "R3";
        drv(1, 8, 32'hFFFF_0000, 1, 8'hFF, 8'h00, 8'hFF, 8'hFF);
        idle(2);
        drv(0, 8, 0, 1, 8'hFE, 8'h00, 8'hFF, 8'hFF);
        idle(2);
        // R4: inbound half-level condition.
        cur_req = "R4";
        drv(1, 8, 32'hFF00_0000, 1, 8'hFF, 8'h00, 8'hFF, 8'hFF);
        idle(2);
        drv(0, 8, 0, 1, 8'hFF, 8'h80, 8'hFF, 8'hFF);
        idle(2);
        drv(0, 8, 0, 1, 8'h7F, 8'h00, 8'hFF, 8'hFF);
        idle(2);
        // R5: outbound not-full condition.
        cur_req = "R5";
        drv(1, 8, 32'h0000_FFFF, 1, 8'hFF, 8'h00, 8'hFF, 8'hFF);
        idle(2);
        drv(0, 8, 0, 1, 8'hFF, 8'h00, 8'hEF, 8'hFF);
        idle(2);
        // R6: outbound below-half condition.
        cur_req = "R6";
        drv(1, 8, 32'h0000_FF00, 1, 8'hFF, 8'h00, 8'hFF, 8'hFF);
        idle(2);
        drv(0, 8, 0, 1, 8'hFF, 8'h00, 8'hFF, 8'h7F);
        idle(2);
        drv(0, 8, 0, 1, 8'hFF, 8'h00, 8'h7F, 8'hEF);
        idle(2);
        // R7: tied selects resist clearing.
        cur_req = "R7";
        drv(1, 8, 32'h1234_5600, 1, 8'hFF, 8'h00, 8'hFF, 8'hFF);
        idle(2);
        // R8: global enable low with active causes.
        cur_req = "R8";
        drv(1, 8, 32'hFFFF_FFFF, 0, 8'h00, 8'hFF, 8'h00, 8'h00);
        idle(3);
        // R9: disabled links and unimplemented-link flags.
        cur_req = "R9";
        drv(1, 8, 32'h0000_0000, 1, 8'h00, 8'hFF, 8'h00, 8'h00);
        idle(2);
        drv(1, 8, 32'h0707_1F1F, 1, 8'hF8, 8'h00, 8'hFF, 8'hFF);
        drv(0, 8, 0, 1, 8'h07, 8'hF8, 8'hFF, 8'hE0);
        idle(2);
        // R11: level held while the cause lasts, dropped one cycle after it clears.
        cur_req = "R11";
        drv(1, 8, 32'hFFFF_FFFF, 1, 8'hFB, 8'h00, 8'hFF, 8'hFF);
        idle(5);
        drv(0, 8, 0, 1, 8'hFF, 8'h00, 8'hFF, 8'hFF);
        idle(3);
        // R10: OR reduction under mixed random patterns.
        cur_req = "R10";
        for (int k = 0; k < 400; k++) begin
            logic [31:0] r = $urandom;
            drv((k % 7) == 0, ((k % 11) == 0) ? 4'd12 : 4'd8, $urandom,
                (k % 13) != 0, r[7:0], r[15:8], r[23:16], r[31:24]);
        end
        idle(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog %s act=running exp=finished", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule